// File: doc/BRIEF.md
# Step Attenuator Control Word Register

This block produces the registered 6-bit control word that drives the binary-weighted stages of a digital step attenuator. Each bit switches in one stage. The stages weigh 0.5, 1, 2, 4, 8 and 16 dB, from bit 0 up to bit 5. The word therefore gives the total attenuation in half-dB units, from 0 dB at all zeros to 31.5 dB at all ones.

A mode input chooses where the word comes from. In serial mode a data pin is shifted into a 6-bit register on rising edges of an external serial clock, most significant bit first. A rising edge of the strobe pin then copies that register into the active word. In parallel mode the six parallel pins feed the word. While the strobe is high the word follows the pins directly. While the strobe is low the word holds its value, and the pin values are taken when the strobe rises.

All external pins are asynchronous to the system clock. They pass through a synchronizer chain, and edges are detected in the system clock domain. Reset forces maximum attenuation whatever the mode and the pins show. A single-cycle update pulse marks every change of the word.

Top module: `step_atten_ctrl`

## Requirements
- R1: The word is an unsigned count of half-dB steps. Bit k adds 2^k half-dB, so pins 6'b100111 yield word 39 (19.5 dB).
- R2: mode_i = 1 selects serial loading and mode_i = 0 selects parallel loading. In serial mode the parallel pins have no effect on the word.
- R3: In serial mode with the strobe low, every synchronized rising edge of sclk_i shifts sdata_i into bit 0 and moves the register one place toward bit 5. A word sent MSB first therefore lands in its own bit order.
- R4: In serial mode, a rising edge of le_i copies the shift register into word_o. At other times the word is stable.
- R5: While le_i is high, sclk_i edges do not change the shift register.
- R6: In parallel mode with le_i high, word_o follows par_i continuously.
- R7: In parallel mode with le_i low, word_o holds its value. When le_i rises, the current par_i value is captured.
- R8: While rst_n is low, and on the first cycle after it, word_o is 6'b111111, whatever mode_i and par_i are.
- R9: The shift register is not cleared by a commit and no bit count is enforced. A strobe after fewer than 6 bits commits the old contents shifted by that many places. The shift register resets to all ones.
- R10: upd_o is high for exactly one cycle after each clock in which word_o took a new value. It stays low when a load gives the same value.
- R11: With the default two synchronizer stages, a pin change applied between clock edges shows on word_o after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = serial load, 0 = parallel load |
| sclk_i | input | 1 | External serial clock |
| sdata_i | input | 1 | External serial data, MSB first |
| le_i | input | 1 | Latch strobe |
| par_i | input | 6 | Parallel attenuation pins |
| word_o | output | 6 | Registered attenuation control word |
| upd_o | output | 1 | One-cycle pulse when word_o changes |

## Verification
On every cycle, the assertions check the holding rules: the word is stable in serial mode without a strobe edge and in parallel mode with the strobe low, and the shift register is frozen while the strobe is high. They also check that a serial commit copies exactly the shift register, that a transparent load copies exactly the synchronized pins, that the word is at maximum on reset exit, and that the update pulse matches word changes in both directions. Only the bench scenarios can show end-to-end behaviour at the pins. That covers MSB-first bit order, that parallel pins are ignored in serial mode, the short-sequence commit, the three-edge latency, and the exact number of update pulses per load.

// File: rtl/atten_pkg.sv
package atten_pkg;

  // Total attenuation of a control word in half-dB units.
  function automatic int unsigned word_half_db(input logic [5:0] w);
    int unsigned acc;
    acc = 0;
    for (int k = 0; k < 6; k++) begin
      if (w[k]) acc += (1 << k);
    end
    return acc;
  endfunction

  // Shift one serial bit into the bottom of a register.
  function automatic logic [5:0] shift_in6(input logic [5:0] r, input logic b);
    return {r[4:0], b};
  endfunction

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/atten_edge.sv
module atten_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter
  import atten_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         serial_mode,
  input  logic         le_lvl,
  input  logic         sclk_rise,
  input  logic         sdata,
  output logic [W-1:0] shreg_o
);
  logic [W-1:0] shreg_q;
  logic         shift_en;

  assign shift_en = serial_mode & ~le_lvl & sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg_q <= '1;
    else if (shift_en) shreg_q <= shift_in6(shreg_q, sdata);
  end

  assign shreg_o = shreg_q;

  AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    le_lvl |=> $stable(shreg_q)); // R5

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (shreg_q[W-1:1] == $past(shreg_q[W-2:0]))); // R3

  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !serial_mode |=> $stable(shreg_q)); // R2
endmodule

// File: rtl/atten_word_sel.sv
module atten_word_sel
  import atten_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         serial_mode,
  input  logic         le_lvl,
  input  logic         le_rise,
  input  logic [W-1:0] shreg,
  input  logic [W-1:0] par,
  output logic [W-1:0] word_o,
  output logic         upd_o
);
  localparam int unsigned MAX_HALF_DB = (1 << W) - 1;

  logic [W-1:0] word_q, word_nxt;
  logic         upd_q;
  logic         serial_commit, par_load;

  assign serial_commit = serial_mode & le_rise;
  assign par_load      = ~serial_mode & le_lvl;

  always_comb begin
    word_nxt = word_q;
    if (serial_commit) word_nxt = shreg;
    else if (par_load) word_nxt = par;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '1;
      upd_q  <= 1'b0;
    end else begin
      word_q <= word_nxt;
      upd_q  <= (word_nxt != word_q);
    end
  end

  assign word_o = word_q;
  assign upd_o  = upd_q;

  AST_RESET_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (word_half_db(6'(word_o)) == MAX_HALF_DB)); // R8

  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_mode && !le_rise) |=> $stable(word_o)); // R4

  AST_SERIAL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    serial_commit |=> (word_o == $past(shreg))); // R4

  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!serial_mode && !le_lvl) |=> $stable(word_o)); // R7

  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    par_load |=> (word_o == $past(par))); // R6

  AST_UPD_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_o != $past(word_o)) |-> upd_o); // R10

  AST_UPD_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (word_o != $past(word_o))); // R10
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int unsigned WORD_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              le_i,
  input  logic [WORD_W-1:0] par_i,
  output logic [WORD_W-1:0] word_o,
  output logic              upd_o
);
  localparam int unsigned BUS_W = WORD_W + 4;
  // Idle levels: serial mode and strobe high (pulled up), clock and data low.
  localparam logic [BUS_W-1:0] SYNC_RST = {1'b1, 1'b1, 1'b0, 1'b0, {WORD_W{1'b0}}};

  logic [BUS_W-1:0]  raw_bus, syn_bus;
  logic              mode_s, le_s, sclk_s, sdata_s;
  logic [WORD_W-1:0] par_s;
  logic              sclk_rise, le_rise;
  logic [WORD_W-1:0] shreg;

  assign raw_bus = {mode_i, le_i, sclk_i, sdata_i, par_i};

  atten_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
  );

  assign {mode_s, le_s, sclk_s, sdata_s, par_s} = syn_bus;

  atten_edge #(.RST_VAL(1'b0)) i_sclk_edge (
    .clk(clk), .rst_n(rst_n), .sig(sclk_s), .rise(sclk_rise)
  );

  atten_edge #(.RST_VAL(1'b1)) i_le_edge (
    .clk(clk), .rst_n(rst_n), .sig(le_s), .rise(le_rise)
  );

  atten_shifter #(.W(WORD_W)) i_shifter (
    .clk(clk), .rst_n(rst_n), .serial_mode(mode_s), .le_lvl(le_s),
    .sclk_rise(sclk_rise), .sdata(sdata_s), .shreg_o(shreg)
  );

  atten_word_sel #(.W(WORD_W)) i_word (
    .clk(clk), .rst_n(rst_n), .serial_mode(mode_s), .le_lvl(le_s),
    .le_rise(le_rise), .shreg(shreg), .par(par_s),
    .word_o(word_o), .upd_o(upd_o)
  );

  AST_EDGES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |-> !$past(le_rise)); // R4
endmodule

// File: tb/test_step_atten_ctrl.sv
module test_step_atten_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b1, sclk = 1'b0, sdata = 1'b0, le = 1'b1;
  logic [5:0] par = 6'd0;
  logic [5:0] word;
  logic       upd;
  int         checks = 0, errors = 0, upd_cnt = 0;

  always #4 clk = ~clk;

  step_atten_ctrl i_step_atten_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .sclk_i(sclk), .sdata_i(sdata),
    .le_i(le), .par_i(par), .word_o(word), .upd_o(upd)
  );

  always @(negedge clk) if (rst_n && upd) upd_cnt++;

  // {mode, load value, expected word}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 6'b010101, 6'h15}, {1'b1, 6'b101010, 6'h2A},
    {1'b1, 6'b000000, 6'h00}, {1'b1, 6'b100111, 6'h27},
    {1'b0, 6'b110011, 6'h33}, {1'b0, 6'b000001, 6'h01},
    {1'b1, 6'b111111, 6'h3F}, {1'b0, 6'b011110, 6'h1E}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata = b; cyc(3); sclk = 1'b1; cyc(3); sclk = 1'b0; cyc(2);
  endtask

  task automatic serial_write(input logic [5:0] v, input int n);
    le = 1'b0; cyc(3);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    le = 1'b1; cyc(5);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] prev;
    int         c0;
    cyc(3);
    chk("R8 in reset", word, 6'h3F);
    rst_n = 1'b1; cyc(5);
    chk("R8 after reset serial", word, 6'h3F);
    prev = 6'h3F;

    for (int k = 0; k < 8; k++) begin
      if (VEC[k][12]) begin
        mode = 1'b1; cyc(4);
        serial_write(VEC[k][11:6], 6);
        chk("R3 R4 serial load", word, VEC[k][5:0]);
      end else begin
        le = 1'b0; cyc(4);
        mode = 1'b0; par = VEC[k][11:6]; cyc(5);
        chk("R7 hold while strobe low", word, prev);
        le = 1'b1; cyc(5);
        chk("R7 capture on strobe rise", word, VEC[k][5:0]);
      end
      prev = VEC[k][5:0];
    end

    // R9: two bits after a 3F word leave 3C
    mode = 1'b1; cyc(4);
    serial_write(6'b000000, 2);
    chk("R9 short sequence", word, 6'h3C);

    // R5: clocks with strobe high must not shift
    for (int i = 0; i < 6; i++) shift_bit(1'b0);
    le = 1'b0; cyc(4); le = 1'b1; cyc(5);
    chk("R5 shifter frozen", word, 6'h3C);

    // R2: pins ignored in serial mode, then take over in parallel mode
    par = 6'h05; cyc(5);
    chk("R2 pins ignored in serial", word, 6'h3C);
    mode = 1'b0; cyc(5);
    chk("R2 parallel selected", word, 6'h05);

    // R6 transparent following
    par = 6'h11; cyc(5);
    chk("R6 follow 11", word, 6'h11);
    par = 6'h22; cyc(5);
    chk("R6 follow 22", word, 6'h22);

    // R1 weights: 16+2+1+0.5 dB = 39 half-dB
    par = 6'b100111; cyc(5);
    chk_int("R1 half-dB value", int'(word), 32 + 4 + 2 + 1);

    // R11 latency
    par = 6'h22; cyc(5);
    par = 6'h2A; cyc(2);
    chk("R11 not after second edge", word, 6'h22);
    cyc(1);
    chk("R11 after third edge", word, 6'h2A);

    // R10 update pulse
    cyc(3); c0 = upd_cnt;
    par = 6'h15; cyc(6);
    chk_int("R10 one pulse per change", upd_cnt - c0, 1);
    c0 = upd_cnt;
    le = 1'b0; cyc(4); le = 1'b1; cyc(6);
    chk_int("R10 no pulse on same value", upd_cnt - c0, 0);

    // R8 reset in parallel mode with zero pins
    par = 6'h00; cyc(5);
    rst_n = 1'b0; cyc(3);
    chk("R8 reset parallel zero pins", word, 6'h3F);
    rst_n = 1'b1; cyc(1);
    chk("R8 first cycle after reset", word, 6'h3F);
    cyc(5);
    chk("R6 transparent resumes", word, 6'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule